// File: doc/BRIEF.md
# Self-Correcting Ring Phase Generator

This block moves a single asserted bit around a shift register, one place per clock. Each output bit is high for exactly one clock in every WIDTH clocks, and no two bits are high at once, so the output bus serves as a set of non-overlapping phase strobes. With the default width of four the bus steps through 1000, 0100, 0010, 0001 and then starts again.

The bit that enters the most significant position is produced by feedback logic. In the default correcting variant that bit is 1 only when every bit above bit 0 is zero. A register that has been corrupted, whether to all zeros or to several ones, therefore returns to the legal cycle within a few clocks without a reset. A parameter can select a plain rotate variant instead, in which bit 0 wraps around to the top and whatever pattern was loaded at reset circulates unchanged. The reset input is asynchronous and active low. Its release is synchronised inside the block, and the register starts from a parameter pattern whose default is 0001.

Top module: `ring_phase_gen`

## Requirements
- R1: While rst_n is low, phase_o equals INIT_PATTERN (default 0001) at once, without waiting for a clock edge.
- R2: After rst_n rises, phase_o holds INIT_PATTERN through the next two rising clock edges and first changes at the third.
- R3: Starting from 0001 with WIDTH=4, the output visits 1000, 0100, 0010, 0001 in that order, advancing one step per clock. The pattern repeats every WIDTH clocks.
- R4: On every advancing clock, output bits [WIDTH-2:0] take the previous values of bits [WIDTH-1:1], which is a shift toward bit 0.
- R5: In the correcting variant (VARIANT=VARIANT_CORRECT, the default), the new bit WIDTH-1 is 1 exactly when the previous bits [WIDTH-1:1] were all zero.
- R6: In the correcting variant, the all-zero state is followed on the next clock by the state with only bit WIDTH-1 set (1000 for WIDTH=4).
- R7: In the correcting variant, a state with more than one bit set reaches a one-hot state within WIDTH-1 clocks. For WIDTH=4, 1111 steps through 0111, 0011, 0001, and 1010 steps through 0101, 0010.
- R8: In the correcting variant, once the state is one-hot it stays one-hot on every later clock.
- R9: In the rotate variant (VARIANT=VARIANT_ROTATE), the new bit WIDTH-1 is the previous bit 0. The number of set bits never changes, so 0101 alternates with 1010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register shifts on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| phase_o | output | WIDTH | Phase strobes; one bit is set in the legal cycle |

## Verification
The bench builds several copies of the block side by side. The first has the default parameters and the legal start 0001. Three more use INIT_PATTERN values of 0000, 1111 and 1010, which puts the corrupted states the correcting feedback must repair within reach of a port with no extra load input. A rotate-variant copy starting at 0101 shows the contrasting behaviour, where an illegal pattern circulates forever. A WIDTH=6 copy starting at 100001 checks that the zero-detect spans the wider upper field and that the period follows the width.

// File: rtl/ring_pkg.sv
package ring_pkg;
  typedef enum logic {
    VARIANT_ROTATE  = 1'b0,
    VARIANT_CORRECT = 1'b1
  } ring_variant_e;
endpackage

// File: rtl/ring_rst_sync.sv
module ring_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/ring_feedback.sv
module ring_feedback
  import ring_pkg::*;
#(
  parameter int            WIDTH   = 4,
  parameter ring_variant_e VARIANT = VARIANT_CORRECT
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             serial_o
);
  generate
    if (VARIANT == VARIANT_CORRECT) begin : g_correct
      // a one enters only when every bit above bit 0 is clear
      assign serial_o = ~|state_i[WIDTH-1:1];
    end else begin : g_rotate
      assign serial_o = state_i[0];
    end
  endgenerate
endmodule

// File: rtl/ring_shift_stage.sv
module ring_shift_stage #(
  parameter int               WIDTH        = 4,
  parameter logic [WIDTH-1:0] INIT_PATTERN = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst_sync_n,
  input  logic             serial_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_d;

  always_comb begin
    state_d = {serial_i, state_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= INIT_PATTERN;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/ring_phase_gen.sv
module ring_phase_gen
  import ring_pkg::*;
#(
  parameter int               WIDTH        = 4,
  parameter ring_variant_e    VARIANT      = VARIANT_CORRECT,
  parameter logic [WIDTH-1:0] INIT_PATTERN = {{(WIDTH-1){1'b0}}, 1'b1}
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] phase_o
);
  logic             rst_sync_n;
  logic             serial_in;
  logic [WIDTH-1:0] phase;

  ring_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ring_feedback #(
    .WIDTH   (WIDTH),
    .VARIANT (VARIANT)
  ) u_feedback (
    .state_i  (phase),
    .serial_o (serial_in)
  );

  ring_shift_stage #(
    .WIDTH        (WIDTH),
    .INIT_PATTERN (INIT_PATTERN)
  ) u_shift (
    .clk        (clk),
    .rst_sync_n (rst_sync_n),
    .serial_i   (serial_in),
    .state_o    (phase)
  );

  assign phase_o = phase;
endmodule

// File: rtl/ring_phase_chk.sv
module ring_phase_chk
  import ring_pkg::*;
#(
  parameter int            WIDTH   = 4,
  parameter ring_variant_e VARIANT = VARIANT_CORRECT
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic [WIDTH-1:0] phase
);
  localparam int CW = $clog2(WIDTH + 1) + 1;

  logic [CW-1:0] bad_run;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      bad_run <= '0;
    end else if ($countones(phase) == 1) begin
      bad_run <= '0;
    end else if (bad_run != '1) begin
      bad_run <= bad_run + 1'b1;
    end
  end

  // R4
  shift_down_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $past(rst_sync_n) |-> phase[WIDTH-2:0] == $past(phase[WIDTH-1:1]));

  generate
    if (VARIANT == VARIANT_CORRECT) begin : g_correct
      // R5
      msb_feed_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        $past(rst_sync_n) |-> phase[WIDTH-1] == ($past(phase[WIDTH-1:1]) == '0));
      // R6
      zero_recover_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        ($past(rst_sync_n) && $past(phase) == '0) |-> phase == {1'b1, {(WIDTH-1){1'b0}}});
      // R8
      onehot_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        ($past(rst_sync_n) && $countones($past(phase)) == 1) |-> $countones(phase) == 1);
      // R7
      recover_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        bad_run < CW'(WIDTH));
    end else begin : g_rotate
      // R9
      ones_kept_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        $past(rst_sync_n) |-> phase[WIDTH-1] == $past(phase[0]));
    end
  endgenerate
endmodule

bind ring_phase_gen ring_phase_chk #(
  .WIDTH   (WIDTH),
  .VARIANT (VARIANT)
) u_phase_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .phase      (phase)
);

// File: tb/test_ring_phase_gen.sv
`timescale 1ns/1ps
module test_ring_phase_gen;
  import ring_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [3:0] ph_main, ph_zero, ph_ones, ph_mix, ph_rot;
  logic [5:0] ph_wide;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  ring_phase_gen i_ring_phase_gen (.clk(clk), .rst_n(rst_n), .phase_o(ph_main));
  ring_phase_gen #(.INIT_PATTERN(4'b0000)) i_ring_phase_gen_zero
    (.clk(clk), .rst_n(rst_n), .phase_o(ph_zero));
  ring_phase_gen #(.INIT_PATTERN(4'b1111)) i_ring_phase_gen_ones
    (.clk(clk), .rst_n(rst_n), .phase_o(ph_ones));
  ring_phase_gen #(.INIT_PATTERN(4'b1010)) i_ring_phase_gen_mix
    (.clk(clk), .rst_n(rst_n), .phase_o(ph_mix));
  ring_phase_gen #(.VARIANT(VARIANT_ROTATE), .INIT_PATTERN(4'b0101)) i_ring_phase_gen_rot
    (.clk(clk), .rst_n(rst_n), .phase_o(ph_rot));
  ring_phase_gen #(.WIDTH(6), .INIT_PATTERN(6'b100001)) i_ring_phase_gen_wide
    (.clk(clk), .rst_n(rst_n), .phase_o(ph_wide));

  // per step after reset release: {main, zero, ones, mix, rot}
  localparam logic [19:0] VEC [8] = '{
    {4'b0001, 4'b0000, 4'b1111, 4'b1010, 4'b0101},
    {4'b1000, 4'b1000, 4'b0111, 4'b0101, 4'b1010},
    {4'b0100, 4'b0100, 4'b0011, 4'b0010, 4'b0101},
    {4'b0010, 4'b0010, 4'b0001, 4'b0001, 4'b1010},
    {4'b0001, 4'b0001, 4'b1000, 4'b1000, 4'b0101},
    {4'b1000, 4'b1000, 4'b0100, 4'b0100, 4'b1010},
    {4'b0100, 4'b0100, 4'b0010, 4'b0010, 4'b0101},
    {4'b0010, 4'b0010, 4'b0001, 4'b0001, 4'b1010}
  };

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 2000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 main reset", {2'b00, ph_main}, 6'b000001);
    check("R1 ones reset", {2'b00, ph_ones}, 6'b001111);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R2 held through two edges after release
    check("R2 main hold", {2'b00, ph_main}, 6'b000001);
    check("R2 wide hold", ph_wide, 6'b100001);

    for (int k = 1; k < 8; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R3 main sequence", {2'b00, ph_main}, {2'b00, VEC[k][19:16]});
      check("R6 zero recovery", {2'b00, ph_zero}, {2'b00, VEC[k][15:12]});
      check("R7 all-ones recovery", {2'b00, ph_ones}, {2'b00, VEC[k][11:8]});
      check("R7 mixed recovery", {2'b00, ph_mix}, {2'b00, VEC[k][7:4]});
      check("R9 rotate variant", {2'b00, ph_rot}, {2'b00, VEC[k][3:0]});
      if (k >= 3)
        check("R8 one-hot kept", 6'($countones(ph_ones)), 6'd1);
      if (k == 1) check("R5 wide feedback", ph_wide, 6'b010000);
      if (k == 7) check("R4 wide period", ph_wide, 6'b010000);
    end

    // mid-run asynchronous reset
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    check("R1 async main", {2'b00, ph_main}, 6'b000001);
    check("R1 async mix", {2'b00, ph_mix}, 6'b001010);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2 hold after mid reset", {2'b00, ph_main}, 6'b000001);
    @(posedge clk);
    @(negedge clk);
    check("R3 first step after mid reset", {2'b00, ph_main}, 6'b001000);
    check("R6 zero first step", {2'b00, ph_zero}, 6'b001000);

    done = 1'b1;
    report();
  end
endmodule